// File: doc/BRIEF.md
# Physical Memory Attribute Lookup

This block keeps a small table of memory-attribute regions and answers, for any byte address, which kind of memory lives there: a 4-bit cacheability and bufferability type, whether atomic read-modify-write operations may target it, and whether the address lies in an empty hole where nothing responds. Software fills the table through an indexed register port. Each entry has an 8-bit configuration register and an address register. The address register encodes a naturally aligned power-of-two window. The window size is given by the number of trailing ones, and the smallest window is 4 KB.

A load/store unit presents a lookup address, together with a flag that marks an atomic access. One cycle later the block returns the attributes of the lowest-numbered entry that matches. It also raises a fault flag when an atomic access targets a region that forbids atomics, and another when any access falls into an empty hole. An address that no entry covers is reported as plain non-cacheable, non-bufferable memory that accepts atomics.

Top module: `mem_attr_lookup`

## Requirements
- R1: After reset every configuration and address register reads zero. Every lookup then misses: hit low, type 2, atomics allowed, no fault.
- R2: A write with `reg_sel`=0 stores bits 6:0 of the write data into the configuration register of entry `reg_idx`, and bit 7 always reads back 0. A write with `reg_sel`=1 stores all 32 bits into the address register. `reg_rdata` shows the selected register in the same cycle.
- R3: The configuration byte has these fields: match mode at bits 1:0, memory type at bits 5:2, atomics-disable at bit 6. Only mode 3 (power-of-two window) enables an entry. Modes 0, 1 and 2 leave the entry inactive.
- R4: The address register holds the byte address shifted right by 2. With k trailing ones, the entry covers 2^(k+3) bytes aligned to that size. An all-ones register covers the whole address space.
- R5: Windows below 4 KB are widened to the enclosing aligned 4 KB window, because bits 8:0 of the address register are treated as ones.
- R6: When several entries match, the lowest index wins. `res_entry` reports that index.
- R7: When no entry matches, the result is hit low, entry 0, type 2 and atomics allowed.
- R8: Types 6, 7, 12, 13 and 14 are reserved and are reported as type 0. All other type codes are reported unchanged.
- R9: Type 15 sets `res_hole`, and every valid lookup that lands on it also sets `fault_hole`.
- R10: `res_amo_ok` is the inverse of bit 6 of the winning entry. `fault_amo` is set when the lookup was atomic and `res_amo_ok` is low.
- R11: Results and fault flags appear one clock after a lookup with `lk_valid` high. `res_valid` repeats `lk_valid` with one cycle of delay, and faults are never raised without it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the configuration register, 1 the address register |
| reg_idx | input | 4 | Entry index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Byte address to look up |
| lk_atomic | input | 1 | Request is an atomic operation |
| res_valid | output | 1 | Result valid |
| res_hit | output | 1 | Some entry matched |
| res_entry | output | 4 | Winning entry index |
| res_type | output | 4 | Reported memory type |
| res_amo_ok | output | 1 | Atomics allowed in region |
| res_hole | output | 1 | Address lies in an empty hole |
| fault_amo | output | 1 | Atomic access to a region that forbids atomics |
| fault_hole | output | 1 | Access to an empty hole |

## Verification
Lookups are aimed at the first and last word inside each window and at the first word past it. This separates a correct size decode from a decode that is off by one bit. A small window nested inside a larger one shows whether the lowest index wins, and switching the inner entry off shows the fall-through to the outer one. A window written as 8 bytes is probed at its 4 KB edge to expose the widening. The bench also covers inactive modes 1 and 2, a reserved type code, a hole, a catch-all entry, and atomic versus plain accesses to the same region, so that each fault flag is checked both set and clear.

// File: rtl/mal_pkg.sv
package mal_pkg;

   localparam int TYPE_W = 4;

   typedef struct packed {
      logic              rsvd;
      logic              amo_dis;
      logic [TYPE_W-1:0] mtype;
      logic [1:0]        mode;
   } mal_cfg_t;

   localparam logic [1:0]        MODE_NAPOT   = 2'd3;
   localparam logic [TYPE_W-1:0] MT_DEV_NB    = 4'd0;
   localparam logic [TYPE_W-1:0] MT_MEM_NC_NB = 4'd2;
   localparam logic [TYPE_W-1:0] MT_HOLE      = 4'd15;

   function automatic logic [TYPE_W-1:0] map_type(input logic [TYPE_W-1:0] t);
      case (t)
         4'd6, 4'd7, 4'd12, 4'd13, 4'd14: return MT_DEV_NB;
         default:                         return t;
      endcase
   endfunction

endpackage

// File: rtl/mal_regfile.sv
module mal_regfile
   import mal_pkg::*;
#(
   parameter int NUM_ENT = 16,
   parameter int ADDR_W  = 32,
   parameter int IDX_W   = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic                              reg_sel,
   input  logic [IDX_W-1:0]                  reg_idx,
   input  logic [ADDR_W-1:0]                 reg_wdata,
   output logic [ADDR_W-1:0]                 reg_rdata,
   output mal_cfg_t [NUM_ENT-1:0]            cfg_o,
   output logic [NUM_ENT-1:0][ADDR_W-1:0]    addr_o
);

   mal_cfg_t [NUM_ENT-1:0]          cfg_q;
   logic [NUM_ENT-1:0][ADDR_W-1:0]  addr_q;
   logic                            idx_ok;

   assign idx_ok = int'(reg_idx) < NUM_ENT;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         addr_q <= '0;
      end else if (reg_we && idx_ok) begin
         if (reg_sel) addr_q[reg_idx] <= reg_wdata;
         else         cfg_q[reg_idx]  <= mal_cfg_t'({1'b0, reg_wdata[6:0]});
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (idx_ok) begin
         if (reg_sel) reg_rdata = addr_q[reg_idx];
         else         reg_rdata = {{(ADDR_W-8){1'b0}}, cfg_q[reg_idx]};
      end
   end

   assign cfg_o  = cfg_q;
   assign addr_o = addr_q;

   // R2: reserved configuration bit never reads back as one
   p_cfg_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_sel |-> !reg_rdata[7]);

   // R2: an address write lands in the addressed register
   p_addr_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_sel && idx_ok) |=> addr_q[$past(reg_idx)] == $past(reg_wdata));

endmodule

// File: rtl/mal_napot_match.sv
module mal_napot_match
   import mal_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_LOG2 = 12
) (
   input  logic [1:0]        mode,
   input  logic [ADDR_W-1:0] areg,
   input  logic [ADDR_W-3:0] word_addr,
   output logic              hit
);

   localparam int                LOW_ONES = GRAN_LOG2 - 3;
   localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << LOW_ONES) - ADDR_W'(1);

   logic [ADDR_W-1:0] eff, span, word;

   always_comb begin
      eff  = areg | LOW_MASK;
      span = eff ^ (eff + ADDR_W'(1));
      word = {2'b00, word_addr};
      hit  = (mode == MODE_NAPOT) && ((word & ~span) == (eff & ~span));
   end

endmodule

// File: rtl/mal_prio_sel.sv
module mal_prio_sel
   import mal_pkg::*;
#(
   parameter int NUM_ENT = 16,
   parameter int IDX_W   = 4
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_ENT-1:0]                hits_i,
   input  logic [NUM_ENT-1:0][TYPE_W-1:0]    type_i,
   input  logic [NUM_ENT-1:0]                amo_dis_i,
   output logic                              any_o,
   output logic [IDX_W-1:0]                  idx_o,
   output logic [TYPE_W-1:0]                 type_o,
   output logic                              amo_ok_o,
   output logic                              hole_o
);

   always_comb begin
      any_o = 1'b0;
      idx_o = '0;
      for (int i = NUM_ENT - 1; i >= 0; i--) begin
         if (hits_i[i]) begin
            any_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
      if (any_o) begin
         type_o   = map_type(type_i[idx_o]);
         amo_ok_o = !amo_dis_i[idx_o];
         hole_o   = type_i[idx_o] == MT_HOLE;
      end else begin
         type_o   = MT_MEM_NC_NB;
         amo_ok_o = 1'b1;
         hole_o   = 1'b0;
      end
   end

   // R6: the chosen entry matched and no lower entry did
   p_first_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any_o |-> (hits_i[idx_o] &&
                 ((hits_i & ((NUM_ENT'(1) << idx_o) - NUM_ENT'(1))) == '0)));

   // R6: a hit is reported exactly when some matcher fired
   p_any_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any_o == (hits_i != '0));

endmodule

// File: rtl/mem_attr_lookup.sv
module mem_attr_lookup
   import mal_pkg::*;
#(
   parameter  int NUM_ENT   = 16,
   parameter  int ADDR_W    = 32,
   parameter  int GRAN_LOG2 = 12,
   parameter  bit REG_OUT   = 1'b1,
   localparam int IDX_W     = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic              reg_sel,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              lk_atomic,
   output logic              res_valid,
   output logic              res_hit,
   output logic [IDX_W-1:0]  res_entry,
   output logic [TYPE_W-1:0] res_type,
   output logic              res_amo_ok,
   output logic              res_hole,
   output logic              fault_amo,
   output logic              fault_hole
);

   if (NUM_ENT < 1) begin : g_bad_ent
      $error("NUM_ENT must be at least 1");
   end
   if (ADDR_W < 16) begin : g_bad_aw
      $error("ADDR_W must be at least 16");
   end
   if (GRAN_LOG2 < 3 || GRAN_LOG2 >= ADDR_W) begin : g_bad_gran
      $error("GRAN_LOG2 out of range");
   end

   mal_cfg_t [NUM_ENT-1:0]              cfg;
   logic [NUM_ENT-1:0][ADDR_W-1:0]      areg;
   logic [NUM_ENT-1:0]                  hits;
   logic [NUM_ENT-1:0][TYPE_W-1:0]      ent_type;
   logic [NUM_ENT-1:0]                  ent_amo_dis;

   logic              c_hit, c_amo_ok, c_hole;
   logic [IDX_W-1:0]  c_idx;
   logic [TYPE_W-1:0] c_type;
   logic              c_fault_amo, c_fault_hole;

   mal_regfile #(.NUM_ENT(NUM_ENT), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
      .clk, .rst_n, .reg_we, .reg_sel, .reg_idx, .reg_wdata, .reg_rdata,
      .cfg_o(cfg), .addr_o(areg)
   );

   for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
      assign ent_type[e]    = cfg[e].mtype;
      assign ent_amo_dis[e] = cfg[e].amo_dis;
      mal_napot_match #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_match (
         .mode(cfg[e].mode), .areg(areg[e]),
         .word_addr(lk_addr[ADDR_W-1:2]), .hit(hits[e])
      );
   end

   mal_prio_sel #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_sel (
      .clk, .rst_n, .hits_i(hits), .type_i(ent_type), .amo_dis_i(ent_amo_dis),
      .any_o(c_hit), .idx_o(c_idx), .type_o(c_type),
      .amo_ok_o(c_amo_ok), .hole_o(c_hole)
   );

   assign c_fault_amo  = lk_valid && lk_atomic && !c_amo_ok;
   assign c_fault_hole = lk_valid && c_hole;

   if (REG_OUT) begin : g_reg_out
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_entry  <= '0;
            res_type   <= MT_MEM_NC_NB;
            res_amo_ok <= 1'b1;
            res_hole   <= 1'b0;
            fault_amo  <= 1'b0;
            fault_hole <= 1'b0;
         end else begin
            res_valid  <= lk_valid;
            fault_amo  <= c_fault_amo;
            fault_hole <= c_fault_hole;
            if (lk_valid) begin
               res_hit    <= c_hit;
               res_entry  <= c_idx;
               res_type   <= c_type;
               res_amo_ok <= c_amo_ok;
               res_hole   <= c_hole;
            end
         end
      end

      // R11: one cycle from request to result
      p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
         lk_valid |=> res_valid);
      p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !lk_valid |=> !res_valid);
   end else begin : g_comb_out
      assign res_valid  = lk_valid;
      assign res_hit    = c_hit;
      assign res_entry  = c_idx;
      assign res_type   = c_type;
      assign res_amo_ok = c_amo_ok;
      assign res_hole   = c_hole;
      assign fault_amo  = c_fault_amo;
      assign fault_hole = c_fault_hole;
   end

   // R7: a miss reports the default attributes
   p_miss_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_hit) |-> (res_type == MT_MEM_NC_NB && res_amo_ok && res_entry == '0));

   // R8: reserved codes never reach the output
   p_type_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> !(res_type inside {4'd6, 4'd7, 4'd12, 4'd13, 4'd14}));

   // R9: hole flag agrees with the reported type
   p_hole_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (res_hole == (res_type == MT_HOLE)));

   // R9: hole fault only with a valid hole result
   p_hole_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fault_hole |-> (res_valid && res_hole));

   // R10: atomic fault only where atomics are forbidden
   p_amo_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
      fault_amo |-> (res_valid && !res_amo_ok));

endmodule

// File: tb/mem_attr_lookup_bench.sv
module mem_attr_lookup_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_sel = 1'b0;
   logic [3:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        lk_valid = 1'b0, lk_atomic = 1'b0;
   logic [31:0] lk_addr = '0;
   logic        res_valid, res_hit, res_amo_ok, res_hole, fault_amo, fault_hole;
   logic [3:0]  res_entry, res_type;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   mem_attr_lookup u_mem_attr_lookup (
      .clk, .rst_n, .reg_we, .reg_sel, .reg_idx, .reg_wdata, .reg_rdata,
      .lk_valid, .lk_addr, .lk_atomic,
      .res_valid, .res_hit, .res_entry, .res_type, .res_amo_ok, .res_hole,
      .fault_amo, .fault_hole
   );

   // vector: addr[43:12] atomic[11] hit[10] idx[9:6] type[5:2] amo_ok[1] hole[0]
   localparam int NV = 13;
   localparam logic [43:0] VEC [NV] = '{
      {32'h1000_0000, 1'b0, 1'b1, 4'd0, 4'd9,  1'b1, 1'b0},
      {32'h1000_FFFC, 1'b1, 1'b1, 4'd0, 4'd9,  1'b1, 1'b0},
      {32'h1001_0000, 1'b1, 1'b1, 4'd1, 4'd4,  1'b0, 1'b0},
      {32'h100F_FFFC, 1'b0, 1'b1, 4'd1, 4'd4,  1'b0, 1'b0},
      {32'h1010_0000, 1'b0, 1'b0, 4'd0, 4'd2,  1'b1, 1'b0},
      {32'h2000_0800, 1'b0, 1'b1, 4'd2, 4'd15, 1'b1, 1'b1},
      {32'h2000_1000, 1'b0, 1'b0, 4'd0, 4'd2,  1'b1, 1'b0},
      {32'h3000_0000, 1'b0, 1'b1, 4'd3, 4'd0,  1'b1, 1'b0},
      {32'h3000_0FFC, 1'b1, 1'b1, 4'd3, 4'd0,  1'b1, 1'b0},
      {32'h3000_1000, 1'b0, 1'b0, 4'd0, 4'd2,  1'b1, 1'b0},
      {32'h4000_0000, 1'b0, 1'b0, 4'd0, 4'd2,  1'b1, 1'b0},
      {32'h5000_0010, 1'b1, 1'b1, 4'd5, 4'd11, 1'b0, 1'b0},
      {32'h0000_0000, 1'b1, 1'b0, 4'd0, 4'd2,  1'b1, 1'b0}
   };
   localparam string VTAG [NV] = '{
      "R4 R10", "R4 R10", "R6 R10", "R4", "R4 R7", "R9", "R4 R7",
      "R5 R8", "R5 R8", "R5 R7", "R3", "R10", "R7 R10"
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [3:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_idx = idx; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_check(input logic sel, input logic [3:0] idx, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_sel = sel; reg_idx = idx;
      #1;
      check(reg_rdata == exp, tag, reg_rdata, exp);
   endtask

   // issue one lookup; outputs are registered and sampled at the next falling edge
   task automatic look(input logic [31:0] a, input logic at);
      @(negedge clk);
      lk_valid = 1'b1; lk_addr = a; lk_atomic = at;
      @(negedge clk);
      lk_valid = 1'b0;
   endtask

   function automatic logic [12:0] got();
      return {res_hit, res_entry, res_type, res_amo_ok, res_hole, fault_amo, fault_hole};
   endfunction

   function automatic logic [12:0] want(input logic at, input logic h, input logic [3:0] i,
                                        input logic [3:0] t, input logic ok, input logic hl);
      return {h, i, t, ok, hl, at & ~ok, hl};
   endfunction

   task automatic look_check(input logic [31:0] a, input logic at, input logic h, input logic [3:0] i,
                             input logic [3:0] t, input logic ok, input logic hl, input string tag);
      logic [12:0] e;
      look(a, at);
      e = want(at, h, i, t, ok, hl);
      check(res_valid && got() == e, tag, {18'd0, res_valid, got()}, {18'd0, 1'b1, e});
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd_check(1'b0, 4'd0, 32'h0, "R1 cfg0 after reset");
      rd_check(1'b1, 4'd5, 32'h0, "R1 addr5 after reset");
      look_check(32'h1000_0000, 1'b1, 1'b0, 4'd0, 4'd2, 1'b1, 1'b0, "R1 lookup after reset");

      // R2: register access
      wr(1'b0, 4'd9, 32'hFFFF_FFFF);
      rd_check(1'b0, 4'd9, 32'h0000_007F, "R2 cfg bit7 reserved");
      wr(1'b1, 4'd9, 32'hDEAD_BEEF);
      rd_check(1'b1, 4'd9, 32'hDEAD_BEEF, "R2 addr readback");
      wr(1'b0, 4'd9, 32'h0);

      // table entries; field layout per R3
      wr(1'b1, 4'd0, 32'h0400_1FFF); wr(1'b0, 4'd0, 32'h27); // 64KB type 9
      wr(1'b1, 4'd1, 32'h0401_FFFF); wr(1'b0, 4'd1, 32'h53); // 1MB type 4 no atomics
      wr(1'b1, 4'd2, 32'h0800_01FF); wr(1'b0, 4'd2, 32'h3F); // 4KB hole
      wr(1'b1, 4'd3, 32'h0C00_0002); wr(1'b0, 4'd3, 32'h1F); // 8B -> 4KB, type 7
      wr(1'b1, 4'd4, 32'h1000_01FF); wr(1'b0, 4'd4, 32'h21); // mode 1 inactive
      wr(1'b1, 4'd5, 32'h1400_01FF); wr(1'b0, 4'd5, 32'h6F); // type 11 no atomics
      rd_check(1'b0, 4'd5, 32'h0000_006F, "R2 cfg readback");

      for (int v = 0; v < NV; v++) begin
         look_check(VEC[v][43:12], VEC[v][11], VEC[v][10], VEC[v][9:6], VEC[v][5:2],
                    VEC[v][1], VEC[v][0], VTAG[v]);
      end

      // R11: idle cycle gives no result and no fault
      @(negedge clk);
      check(!res_valid && !fault_amo && !fault_hole, "R11 idle",
            {29'd0, res_valid, fault_amo, fault_hole}, 32'h0);

      // R3: mode 2 still inactive, mode 3 activates
      wr(1'b0, 4'd4, 32'h22);
      look_check(32'h4000_0000, 1'b0, 1'b0, 4'd0, 4'd2, 1'b1, 1'b0, "R3 mode2 inactive");
      wr(1'b0, 4'd4, 32'h23);
      look_check(32'h4000_0000, 1'b0, 1'b1, 4'd4, 4'd8, 1'b1, 1'b0, "R3 mode3 active");

      // R4 R6: all-ones catch-all at the highest index
      wr(1'b1, 4'd15, 32'hFFFF_FFFF); wr(1'b0, 4'd15, 32'h0F);
      look_check(32'h7000_0000, 1'b1, 1'b1, 4'd15, 4'd3, 1'b1, 1'b0, "R4 catch-all");
      look_check(32'h1000_0004, 1'b0, 1'b1, 4'd0, 4'd9, 1'b1, 1'b0, "R6 low index over catch-all");

      // R6 R10: turn off inner entry, outer entry takes over
      wr(1'b0, 4'd0, 32'h0);
      look_check(32'h1000_0000, 1'b1, 1'b1, 4'd1, 4'd4, 1'b0, 1'b0, "R6 fall-through");
      look_check(32'h2000_0000, 1'b1, 1'b1, 4'd2, 4'd15, 1'b1, 1'b1, "R9 atomic into hole");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule